// File: doc/BRIEF.md
# Programmable-Length Serial Shift Engine

This block moves one word of 2 to 16 bits at a time over a pair of serial data lines under a serial clock. As master it makes the serial clock itself from the system clock with an 8-bit divider and drives an active-low select line around each word. As slave it follows a serial clock and select that come from outside, and it shifts the armed word out as the external clock runs.

Each word comes in through a parallel valid/ready handshake together with a format index. The index picks one of four format entries, and each entry holds a character length, a clock idle level, a clock phase and a divider. A received word goes into a holding register with a valid flag. The shifter can then start the next word while the last one waits to be read. If a word completes while the holding register is still unread, the old contents are replaced and an overrun flag is set.

Top module: `spi_shift_engine`

## Requirements
- R1: A write with `cfg_we` high stores length, polarity, phase and divider into entry `cfg_idx`. The length value is clamped: raw values below 2 act as 2 and values above 16 act as 16.
- R2: In master mode (`master_en`=1) an accepted word holds `sel_n_o` low and `tx_ready` low. This starts in the cycle after the accepting edge and lasts until (2L+1)(D+1) cycles after it, where L is the length and D the divider of the chosen format. Both then return high.
- R3: In master mode `sclk_o` takes the polarity value at acceptance. It then toggles every D+1 cycles, exactly 2L times, and stays still during the final D+1 cycle tail before `sel_n_o` rises.
- R4: The low L bits of `tx_data` are sent most significant first, and bits above L are ignored. With phase 0 the first bit is on `ser_do` while select is first low, and each later bit follows a trailing edge. With phase 1 `ser_do` is 0 until the first leading edge, and each bit follows a leading edge.
- R5: Phase 0 samples `ser_di` on leading (odd-numbered) clock edges and phase 1 on trailing edges. `rx_data` holds the L received bits right-aligned, first received bit most significant, with zeros above.
- R6: `rx_valid` rises together with the word's end (master: the same edge that raises `sel_n_o`). A one-cycle `rx_read` pulse clears it.
- R7: If a word completes while `rx_valid` is high and no read is pending, `rx_overrun` rises and `rx_data` takes the new word. `rx_read` clears `rx_overrun`.
- R8: Every word uses the format that its own `tx_fmt` index selected when it was accepted, so consecutive words may differ in length, polarity, phase and divider.
- R9: In slave mode (`master_en`=0) an accepted word waits until `sel_n_i` is low. It is then shifted by transitions of `sclk_i`, with the same phase rules and the same bit order as R4/R5, and it completes after 2L transitions. `sel_n_o` stays high throughout.
- R10: In slave mode, if `sel_n_i` rises after at least one clock transition but before 2L of them, the word is dropped. `rx_valid` is not set, and `tx_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1 = master, 0 = slave; change only while idle |
| cfg_we | input | 1 | Format entry write strobe |
| cfg_idx | input | 2 | Format entry to write |
| cfg_len | input | 5 | Character length (clamped to 2..16) |
| cfg_pol | input | 1 | Serial clock idle level |
| cfg_pha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_div | input | 8 | Half-period of the serial clock minus one, in system clocks |
| tx_valid | input | 1 | Word offered for transfer |
| tx_ready | output | 1 | Engine idle and able to accept a word |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_fmt | input | 2 | Format entry for this word |
| rx_read | input | 1 | Consume the received word |
| rx_valid | output | 1 | Received word waiting |
| rx_data | output | 16 | Received word, right-aligned |
| rx_overrun | output | 1 | A waiting word was overwritten |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| sel_n_o | output | 1 | Active-low select driven in master mode |
| sel_n_i | input | 1 | Active-low select received in slave mode |
| ser_do | output | 1 | Serial data out |
| ser_di | input | 1 | Serial data in |

## Verification
The hardest situation to reach is a slave word that is cut short. It needs an armed word, the external select low, a few synchronized clock transitions and then the select released before the count ends. The bench plays the external master itself with a slow serial clock, gives three transitions and releases select. It then confirms at the ports that no word was delivered and that the engine accepts work again. Master words run with a looped-back data line, inverted on some words. A per-cycle model built from the timing formulas predicts clock, select, data and receive results, and checks them on every cycle across all four formats. Clamping of out-of-range lengths is checked the same way.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int unsigned WORD_W  = 16;
  localparam int unsigned MIN_LEN = 2;
  localparam int unsigned DIV_W   = 8;
  localparam int unsigned LEN_W   = $clog2(WORD_W + 1);
  localparam int unsigned EDGE_W  = $clog2(2 * WORD_W + 1);

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             pol;
    logic             pha;
    logic [DIV_W-1:0] div;
  } fmt_t;

  // Keep a requested length inside the supported window.
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
    if (raw < LEN_W'(MIN_LEN)) return LEN_W'(MIN_LEN);
    if (raw > LEN_W'(WORD_W))  return LEN_W'(WORD_W);
    return raw;
  endfunction

  // Move the low len bits of a word to the top of the shift register.
  function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] d,
                                                  input logic [LEN_W-1:0]  len);
    return d << (WORD_W - 32'(len));
  endfunction

  // Ones in the low len bit positions.
  function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    return {WORD_W{1'b1}} >> (WORD_W - 32'(len));
  endfunction

  // Number of serial clock transitions in one word.
  function automatic logic [EDGE_W-1:0] edge_total(input logic [LEN_W-1:0] len);
    return EDGE_W'(32'(len) << 1);
  endfunction

endpackage

// File: rtl/spi_fmt_bank.sv
module spi_fmt_bank import spi_eng_pkg::*; #(
  parameter int unsigned NUM_FMT = 4,
  parameter int unsigned FIDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FIDX_W-1:0] wr_idx,
  input  fmt_t              wr_fmt,
  input  logic [FIDX_W-1:0] rd_idx,
  output fmt_t              rd_fmt
);

  fmt_t ent_arr [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_entry
    fmt_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '{len: LEN_W'(WORD_W), pol: 1'b0, pha: 1'b0, div: '0};
      end else if (wr_en && (wr_idx == FIDX_W'(g))) begin
        q <= '{len: clamp_len(wr_fmt.len), pol: wr_fmt.pol,
               pha: wr_fmt.pha, div: wr_fmt.div};
      end
    end
    assign ent_arr[g] = q;
  end

  assign rd_fmt = ent_arr[rd_idx];

  // R1: every entry read out carries a length inside 2..16
  assert_len_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fmt.len >= LEN_W'(MIN_LEN)) && (rd_fmt.len <= LEN_W'(WORD_W)));

endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sel_n_in,
  input  logic di_in,
  output logic edge_seen,
  output logic sel_act,
  output logic di_s
);

  logic sclk_m, sclk_s, sclk_p;
  logic sel_m, sel_s;
  logic di_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_m <= 1'b0;
      sclk_s <= 1'b0;
      sclk_p <= 1'b0;
      sel_m  <= 1'b1;
      sel_s  <= 1'b1;
      di_m   <= 1'b0;
      di_s   <= 1'b0;
    end else begin
      sclk_m <= sclk_in;
      sclk_s <= sclk_m;
      sclk_p <= sclk_s;
      sel_m  <= sel_n_in;
      sel_s  <= sel_m;
      di_m   <= di_in;
      di_s   <= di_m;
    end
  end

  assign edge_seen = sclk_s ^ sclk_p;
  assign sel_act   = !sel_s;

endmodule

// File: rtl/spi_rx_buf.sv
module spi_rx_buf import spi_eng_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              overrun
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr) begin
        valid <= 1'b1;
        data  <= wdata;
        if (valid && !rd) overrun <= 1'b1;
        else if (rd)      overrun <= 1'b0;
      end else if (rd) begin
        valid   <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

  // R7: completing a word over an unread one raises the overrun flag
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && valid && !rd) |=> overrun);

  // R6: a read with no new word empties the holding register
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> (!valid && !overrun));

endmodule

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl import spi_eng_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  input  fmt_t              fmt_in,
  output logic              tx_ready,
  input  logic              sl_edge,
  input  logic              sl_sel,
  input  logic              sl_di,
  input  logic              ser_di,
  output logic              ser_do,
  output logic              sclk_o,
  output logic              sel_n_o,
  output logic              done,
  output logic [WORD_W-1:0] done_data
);

  typedef enum logic [1:0] {ST_IDLE, ST_MRUN, ST_MTAIL, ST_SRUN} st_t;

  st_t               st;
  fmt_t              cur;
  logic [WORD_W-1:0] txsh, rxsh, aligned, rx_next;
  logic [DIV_W-1:0]  cnt;
  logic [EDGE_W-1:0] edges;
  logic              out_q, sclk_q, sel_q;

  // Named internal events
  logic accept, tick, edge_ev, lead, trail, last_edge;
  logic capture, launch, in_bit, tail_end, slave_end, slave_abort;

  assign aligned     = align_msb(tx_data, fmt_in.len);
  assign accept      = tx_valid && (st == ST_IDLE);
  assign tick        = (cnt == cur.div);
  assign edge_ev     = ((st == ST_MRUN) && tick) ||
                       ((st == ST_SRUN) && sl_edge && sl_sel);
  assign lead        = edge_ev && !edges[0];
  assign trail       = edge_ev && edges[0];
  assign last_edge   = edge_ev && (edges == edge_total(cur.len) - 1'b1);
  assign capture     = cur.pha ? trail : lead;
  assign launch      = cur.pha ? lead : (trail && !last_edge);
  assign in_bit      = (st == ST_SRUN) ? sl_di : ser_di;
  assign rx_next     = capture ? {rxsh[WORD_W-2:0], in_bit} : rxsh;
  assign tail_end    = (st == ST_MTAIL) && tick;
  assign slave_end   = (st == ST_SRUN) && last_edge;
  assign slave_abort = (st == ST_SRUN) && !sl_sel && (edges != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur    <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      cnt    <= '0;
      edges  <= '0;
      out_q  <= 1'b0;
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            cur    <= fmt_in;
            sclk_q <= fmt_in.pol;
            cnt    <= '0;
            edges  <= '0;
            rxsh   <= '0;
            if (!fmt_in.pha) begin
              out_q <= aligned[WORD_W-1];
              txsh  <= aligned << 1;
            end else begin
              out_q <= 1'b0;
              txsh  <= aligned;
            end
            st    <= master_en ? ST_MRUN : ST_SRUN;
            sel_q <= !master_en;
          end
        end
        ST_MRUN: begin
          if (tick) begin
            cnt    <= '0;
            sclk_q <= !sclk_q;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_MTAIL: begin
          if (tick) begin
            cnt   <= '0;
            st    <= ST_IDLE;
            sel_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SRUN: begin
          if (slave_abort) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase

      if (edge_ev) edges <= edges + 1'b1;
      if (capture) rxsh <= rx_next;
      if (launch) begin
        out_q <= txsh[WORD_W-1];
        txsh  <= txsh << 1;
      end
      if (last_edge) begin
        st  <= (st == ST_MRUN) ? ST_MTAIL : ST_IDLE;
        cnt <= '0;
      end
    end
  end

  assign tx_ready  = (st == ST_IDLE);
  assign ser_do    = out_q;
  assign sclk_o    = sclk_q;
  assign sel_n_o   = sel_q;
  assign done      = tail_end || slave_end;
  assign done_data = rx_next & len_mask(cur.len);

  // R2: a handshake moves the engine out of idle on the next cycle
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R2: select stays low for every master cycle of a word
  assert_sel_low_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_MRUN) || (st == ST_MTAIL)) |-> !sel_n_o);

  // R3: the serial clock is quiet during the tail before select is released
  assert_tail_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MTAIL) |=> $stable(sclk_o));

  // R3: the edge counter never passes twice the word length
  assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> (edges <= edge_total(cur.len)));

  // R9: a slave word never drives the select output
  assert_slave_sel_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SRUN) |-> sel_n_o);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine import spi_eng_pkg::*; #(
  parameter  int unsigned NUM_FMT = 4,
  localparam int unsigned FIDX_W  = (NUM_FMT > 1) ? $clog2(NUM_FMT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              cfg_we,
  input  logic [FIDX_W-1:0] cfg_idx,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_pol,
  input  logic              cfg_pha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  input  logic [FIDX_W-1:0] tx_fmt,
  input  logic              rx_read,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_overrun,
  output logic              sclk_o,
  input  logic              sclk_i,
  output logic              sel_n_o,
  input  logic              sel_n_i,
  output logic              ser_do,
  input  logic              ser_di
);

  fmt_t              wr_fmt, sel_fmt;
  logic              sl_edge, sl_sel, sl_di;
  logic              word_done;
  logic [WORD_W-1:0] word_data;

  assign wr_fmt = '{len: cfg_len, pol: cfg_pol, pha: cfg_pha, div: cfg_div};

  spi_fmt_bank #(.NUM_FMT(NUM_FMT), .FIDX_W(FIDX_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_idx),
    .wr_fmt (wr_fmt),
    .rd_idx (tx_fmt),
    .rd_fmt (sel_fmt)
  );

  spi_slave_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_in   (sclk_i),
    .sel_n_in  (sel_n_i),
    .di_in     (ser_di),
    .edge_seen (sl_edge),
    .sel_act   (sl_sel),
    .di_s      (sl_di)
  );

  spi_word_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .fmt_in    (sel_fmt),
    .tx_ready  (tx_ready),
    .sl_edge   (sl_edge),
    .sl_sel    (sl_sel),
    .sl_di     (sl_di),
    .ser_di    (ser_di),
    .ser_do    (ser_do),
    .sclk_o    (sclk_o),
    .sel_n_o   (sel_n_o),
    .done      (word_done),
    .done_data (word_data)
  );

  spi_rx_buf u_rxbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (word_done),
    .wdata   (word_data),
    .rd      (rx_read),
    .valid   (rx_valid),
    .data    (rx_data),
    .overrun (rx_overrun)
  );

endmodule

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, master_en, cfg_we, cfg_pol, cfg_pha;
  logic [1:0]  cfg_idx, tx_fmt;
  logic [4:0]  cfg_len;
  logic [7:0]  cfg_div;
  logic        tx_valid, rx_read, sclk_i, sel_n_i, tb_di, inv;
  logic [15:0] tx_data;
  wire         tx_ready, rx_valid, rx_overrun, sclk_o, sel_n_o, ser_do, ser_di;
  wire  [15:0] rx_data;

  // Master words loop the output back (optionally inverted); slave words get bench data.
  assign ser_di = master_en ? (ser_do ^ inv) : tb_di;

  spi_shift_engine uut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_len(cfg_len), .cfg_pol(cfg_pol),
    .cfg_pha(cfg_pha), .cfg_div(cfg_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_fmt(tx_fmt),
    .rx_read(rx_read), .rx_valid(rx_valid), .rx_data(rx_data), .rx_overrun(rx_overrun),
    .sclk_o(sclk_o), .sclk_i(sclk_i), .sel_n_o(sel_n_o), .sel_n_i(sel_n_i),
    .ser_do(ser_do), .ser_di(ser_di)
  );

  int nvec = 0;
  int nbad = 0;
  int bl[4], bp[4], bh[4], bd[4];   // bench copy of the formats

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cfg(input int idx, input int len_raw, input int pol, input int pha, input int dv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_len = len_raw[4:0];
    cfg_pol = pol[0]; cfg_pha = pha[0]; cfg_div = dv[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
    bl[idx] = (len_raw < 2) ? 2 : ((len_raw > 16) ? 16 : len_raw);   // R1 clamp
    bp[idx] = pol; bh[idx] = pha; bd[idx] = dv;
  endtask

  // Per-cycle reference of a master word, from the timing formulas of R2..R7.
  task automatic master_word(input int idx, input int data, input logic inv_i,
                             input int exp_ovr, input string tag);
    int L = bl[idx];
    int H = bd[idx] + 1;
    int P = bp[idx];
    int A = bh[idx];
    int fin = (2 * L + 1) * H;
    int mask = (1 << L) - 1;
    int m = data & mask;
    int e, b, expd;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = data[15:0]; tx_fmt = idx[1:0]; inv = inv_i;
    @(posedge clk);
    for (int t = 0; t <= fin; t++) begin
      @(negedge clk);
      tx_valid = 1'b0;
      e = t / H;
      if (e > 2 * L) e = 2 * L;
      check({"R3 ", tag}, "sclk_o", 32'(sclk_o), 32'(P ^ (e % 2)));
      check({"R2 ", tag}, "sel_n_o", 32'(sel_n_o), (t < fin) ? 32'd0 : 32'd1);
      check({"R2 ", tag}, "tx_ready", 32'(tx_ready), (t < fin) ? 32'd0 : 32'd1);
      if (t < fin) begin
        if (A == 0) begin
          b = e / 2;
          if (b > L - 1) b = L - 1;
          expd = (m >> (L - 1 - b)) & 1;
        end else if (e == 0) begin
          expd = 0;
        end else begin
          b = (e - 1) / 2;
          expd = (m >> (L - 1 - b)) & 1;
        end
        check({"R4 ", tag}, "ser_do", 32'(ser_do), 32'(expd));
      end else begin
        check({"R6 ", tag}, "rx_valid", 32'(rx_valid), 32'd1);
        check({"R5 ", tag}, "rx_data", 32'(rx_data), 32'(inv_i ? (m ^ mask) : m));
        check({"R7 ", tag}, "rx_overrun", 32'(rx_overrun), 32'(exp_ovr));
      end
    end
  endtask

  task automatic rd_rx;
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
    check("R6", "rx_valid after read", 32'(rx_valid), 32'd0);
    check("R7", "rx_overrun after read", 32'(rx_overrun), 32'd0);
  endtask

  task automatic slave_arm(input int idx, input int txd);
    @(negedge clk);
    sclk_i = bp[idx][0]; sel_n_i = 1'b1;
    repeat (4) @(negedge clk);
    tx_valid = 1'b1; tx_data = txd[15:0]; tx_fmt = idx[1:0];
    @(negedge clk);
    tx_valid = 1'b0;
    check("R9", "tx_ready while armed", 32'(tx_ready), 32'd0);
  endtask

  // Bench acts as the external master with a 12-cycle serial clock period.
  task automatic slave_word(input int idx, input int txd, input int dp);
    int L = bl[idx];
    int P = bp[idx];
    int A = bh[idx];
    int mask = (1 << L) - 1;
    int mt = txd & mask;
    slave_arm(idx, txd);
    tb_di = (A == 0) ? dp[L-1] : 1'b0;
    sel_n_i = 1'b0;
    repeat (6) @(negedge clk);
    for (int b = L - 1; b >= 0; b--) begin
      if (A == 0) begin
        check("R9", "slave ser_do", 32'(ser_do), 32'((mt >> b) & 1));
        sclk_i = (P == 0);
        repeat (6) @(negedge clk);
        sclk_i = (P != 0);
        tb_di = (b > 0) ? dp[b-1] : 1'b0;
        repeat (6) @(negedge clk);
      end else begin
        tb_di = dp[b];
        sclk_i = (P == 0);
        repeat (6) @(negedge clk);
        check("R9", "slave ser_do", 32'(ser_do), 32'((mt >> b) & 1));
        sclk_i = (P != 0);
        repeat (6) @(negedge clk);
      end
      check("R9", "sel_n_o in slave", 32'(sel_n_o), 32'd1);
    end
    sel_n_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R9", "slave rx_valid", 32'(rx_valid), 32'd1);
    check("R9", "slave rx_data", 32'(rx_data), 32'(dp & mask));
    check("R9", "slave tx_ready", 32'(tx_ready), 32'd1);
  endtask

  task automatic slave_abort(input int idx, input int txd);
    int P = bp[idx];
    slave_arm(idx, txd);
    sel_n_i = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sclk_i = ~sclk_i;
      repeat (6) @(negedge clk);
    end
    sel_n_i = 1'b1;
    repeat (8) @(negedge clk);
    check("R10", "tx_ready after abort", 32'(tx_ready), 32'd1);
    check("R10", "rx_valid after abort", 32'(rx_valid), 32'd0);
    sclk_i = P[0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; master_en = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_len = '0;
    cfg_pol = 1'b0; cfg_pha = 1'b0; cfg_div = '0; tx_valid = 1'b0; tx_data = '0;
    tx_fmt = '0; rx_read = 1'b0; sclk_i = 1'b0; sel_n_i = 1'b1; tb_di = 1'b0; inv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "reset sel_n_o", 32'(sel_n_o), 32'd1);
    check("R2", "reset tx_ready", 32'(tx_ready), 32'd1);
    check("R6", "reset rx_valid", 32'(rx_valid), 32'd0);
    check("R7", "reset rx_overrun", 32'(rx_overrun), 32'd0);
    check("R3", "reset sclk_o", 32'(sclk_o), 32'd0);

    cfg(0, 8, 0, 0, 0);
    cfg(1, 16, 1, 1, 2);
    cfg(2, 2, 1, 0, 1);
    cfg(3, 1, 0, 1, 0);          // R1: raw length 1 acts as 2

    master_word(0, 'hA5, 1'b0, 0, "R8 fmt0");
    rd_rx();
    master_word(1, 'hBEEF, 1'b1, 0, "R8 fmt1");
    rd_rx();
    master_word(2, 'hFFF2, 1'b0, 0, "R4 upper bits ignored");
    rd_rx();
    master_word(3, 'h0001, 1'b1, 0, "R1 low clamp");
    rd_rx();

    cfg(3, 25, 1, 1, 3);         // R1: raw length 25 acts as 16
    master_word(3, 'h8001, 1'b0, 0, "R1 high clamp");
    master_word(0, 'h5A, 1'b1, 1, "R7 overrun");
    rd_rx();

    @(negedge clk); master_en = 1'b0;
    slave_word(0, 'h3C, 'h96);
    rd_rx();
    slave_word(1, 'h1234, 'hC0DE);
    rd_rx();
    slave_abort(0, 'h77);

    @(negedge clk); master_en = 1'b1;
    master_word(2, 'h0001, 1'b0, 0, "R10 recovery");
    rd_rx();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule